// File: doc/BRIEF.md
# SPI Memory Slave Command Front-End

This block is the serial side of a byte-wide memory that answers an SPI master. All four serial pins (clock, chip select, pause and data in) are brought into the core clock domain through a short synchronizer and oversampled, so the block never runs on the serial clock. The first byte after a select is decoded as a command. Read and write commands then take a two-byte address. Data bytes move in both directions, most significant bit first.

Toward the memory core the block gives one-cycle strobes: write-enable set, write-enable clear, read fetch, data write and status write. It also holds an address bus and a data bus. Read data and status come back from the core on two byte inputs, and a single `wr_allow` input gates both kinds of write strobe. The serial output has its own drive-enable, so a pad cell can float the pin.

A pause line lets the master stall a transfer in the middle of a byte. An unrecognised command makes the block deaf and mute until the next select.

Top module: `spi_mem_front`

## Requirements
- R1: Serial mode 0 with most significant bit first: data in is taken on a rising serial clock edge, and data out changes only on a falling edge.
- R2: The first eight bits after chip select falls form the command. The recognised codes are 0x06, 0x04, 0x05, 0x01, 0x03 and 0x02.
- R3: Command 0x06 gives exactly one `cmd_wren` pulse and command 0x04 gives exactly one `cmd_wrdi` pulse. Any bytes that follow have no effect.
- R4: Command 0x03 takes a 16-bit address, high byte first, of which only the low 13 bits are kept. It then shifts out `rd_data` for `mem_addr`. After each byte the address goes up by one, wraps from 0x1FFF to 0x0000, and a `rd_req` pulse carries the new address.
- R5: Command 0x05 shifts out `sr_data` for every byte clocked while the select is held.
- R6: Command 0x02 takes a 13-bit address in the same way. Each completed data byte gives one `wr_stb` with that byte on `wr_data` and the current `mem_addr`, and the address then goes up by one. There is no strobe while `wr_allow` is low.
- R7: Command 0x01 puts its first data byte on `wr_data` with one `sr_wr_stb`, gated by `wr_allow`. Later bytes are ignored.
- R8: After an unrecognised command byte, no strobe is raised, serial data is ignored and `so_oe` stays low until chip select falls again.
- R9: While chip select is high, `so_oe` is low and serial clock and data have no effect. Raising chip select mid-byte discards the partial byte and produces no strobe.
- R10: A pause starts when the pause line is low while the serial clock is low, and ends when the line is high while the clock is low. During a pause, `so_oe` is low and clock edges and data in are ignored. The bit position and the output bit are kept.
- R11: At most one of the five core strobes is high in any cycle.
- R12: During reset and after it, with no select, `so_oe` and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from the master |
| cs_n | input | 1 | Active-low chip select |
| hold_n | input | 1 | Active-low transfer pause |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Drive-enable for the serial data out pin |
| wr_allow | input | 1 | Core permits write and status-write strobes |
| rd_data | input | 8 | Core data for `mem_addr`, needed by the next falling serial clock edge |
| sr_data | input | 8 | Core status byte |
| cmd_wren | output | 1 | Write-enable set pulse |
| cmd_wrdi | output | 1 | Write-enable clear pulse |
| rd_req | output | 1 | Read fetch pulse for `mem_addr` |
| wr_stb | output | 1 | Data write pulse |
| sr_wr_stb | output | 1 | Status write pulse |
| mem_addr | output | 13 | Current memory address |
| wr_data | output | 8 | Byte for data or status write |

## Verification
If the bit counter slips, the next command or data byte is framed wrong. That shows as a wrong or missing strobe within one byte time, or as read bytes shifted by one bit. A pause that does not freeze state corrupts the byte that was paused: the garbage clocked during the pause lands in `wr_data`, or the read stream loses bits as soon as the pause ends. A stuck dead or idle state shows on the next select as a missing strobe or a floating output, and an address that increments wrongly shows in the first read byte after the wrap.

// File: rtl/spi_mem_front.sv
module spi_mem_front #(
  parameter int ADDR_W      = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              hold_n,
  input  logic              si,
  output logic              so,
  output logic              so_oe,
  input  logic              wr_allow,
  input  logic [7:0]        rd_data,
  input  logic [7:0]        sr_data,
  output logic              cmd_wren,
  output logic              cmd_wrdi,
  output logic              rd_req,
  output logic              wr_stb,
  output logic              sr_wr_stb,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        wr_data
);

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_WRIT = 8'h02;

  typedef enum logic [2:0] {
    ST_OP, ST_ADDR, ST_WR, ST_RD, ST_SRRD, ST_SRWR, ST_IDLE, ST_DEAD
  } st_t;

  logic [SYNC_STAGES-1:0] sck_q, cs_q, hold_q, si_q;
  logic p_sck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= '0;
      cs_q   <= '1;
      hold_q <= '1;
      si_q   <= '0;
      p_sck  <= 1'b0;
    end else begin
      sck_q  <= {sck_q[SYNC_STAGES-2:0], sck};
      cs_q   <= {cs_q[SYNC_STAGES-2:0], cs_n};
      hold_q <= {hold_q[SYNC_STAGES-2:0], hold_n};
      si_q   <= {si_q[SYNC_STAGES-2:0], si};
      p_sck  <= sck_q[SYNC_STAGES-1];
    end
  end

  wire s_sck  = sck_q[SYNC_STAGES-1];
  wire s_cs   = cs_q[SYNC_STAGES-1];
  wire s_hold = hold_q[SYNC_STAGES-1];
  wire s_si   = si_q[SYNC_STAGES-1];

  st_t        st;
  logic [2:0] bitcnt;
  logic [6:0] shin;
  logic [7:0] shout;
  logic [7:0] addr_hi;
  logic       addr_lo, is_read, held, out_en, wr_inc;

  wire        active    = ~s_cs & ~held;
  wire        take      = active & s_sck & ~p_sck;
  wire        drop      = active & ~s_sck & p_sck;
  wire        byte_done = take & (bitcnt == 3'd7) & (st != ST_DEAD);
  wire [7:0]  rx_byte   = {shin, s_si};
  wire        out_phase = (st == ST_RD) | (st == ST_SRRD);
  wire [7:0]  out_src   = (st == ST_SRRD) ? sr_data : rd_data;
  wire [15:0] addr_word = {addr_hi, rx_byte};
  wire        unused_hi = ^addr_word[15:ADDR_W];

  wire in_dead = (st == ST_DEAD);
  wire in_rd   = (st == ST_RD);

  assign so_oe = out_en & out_phase & active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_OP;
      bitcnt    <= '0;
      shin      <= '0;
      shout     <= '0;
      addr_hi   <= '0;
      addr_lo   <= 1'b0;
      is_read   <= 1'b0;
      held      <= 1'b0;
      out_en    <= 1'b0;
      wr_inc    <= 1'b0;
      so        <= 1'b0;
      cmd_wren  <= 1'b0;
      cmd_wrdi  <= 1'b0;
      rd_req    <= 1'b0;
      wr_stb    <= 1'b0;
      sr_wr_stb <= 1'b0;
      mem_addr  <= '0;
      wr_data   <= '0;
    end else begin
      cmd_wren  <= 1'b0;
      cmd_wrdi  <= 1'b0;
      rd_req    <= 1'b0;
      wr_stb    <= 1'b0;
      sr_wr_stb <= 1'b0;
      wr_inc    <= 1'b0;
      if (wr_inc) mem_addr <= mem_addr + 1'b1;

      if (s_cs) begin
        st      <= ST_OP;
        bitcnt  <= '0;
        held    <= 1'b0;
        out_en  <= 1'b0;
        addr_lo <= 1'b0;
      end else begin
        if (!held && !s_hold && !s_sck) held <= 1'b1;
        else if (held && s_hold && !s_sck) held <= 1'b0;

        if (take && st != ST_DEAD) begin
          bitcnt <= bitcnt + 3'd1;
          shin   <= rx_byte[6:0];
        end

        if (byte_done) begin
          case (st)
            ST_OP: begin
              case (rx_byte)
                OP_WREN: begin cmd_wren <= 1'b1; st <= ST_IDLE; end
                OP_WRDI: begin cmd_wrdi <= 1'b1; st <= ST_IDLE; end
                OP_RDSR: st <= ST_SRRD;
                OP_WRSR: st <= ST_SRWR;
                OP_READ: begin is_read <= 1'b1; addr_lo <= 1'b0; st <= ST_ADDR; end
                OP_WRIT: begin is_read <= 1'b0; addr_lo <= 1'b0; st <= ST_ADDR; end
                default: st <= ST_DEAD;
              endcase
            end
            ST_ADDR: begin
              if (!addr_lo) begin
                addr_hi <= rx_byte;
                addr_lo <= 1'b1;
              end else begin
                mem_addr <= addr_word[ADDR_W-1:0];
                if (is_read) begin
                  rd_req <= 1'b1;
                  st     <= ST_RD;
                end else begin
                  st <= ST_WR;
                end
              end
            end
            ST_WR: begin
              wr_data <= rx_byte;
              wr_stb  <= wr_allow;
              wr_inc  <= 1'b1;
            end
            ST_SRWR: begin
              wr_data   <= rx_byte;
              sr_wr_stb <= wr_allow;
              st        <= ST_IDLE;
            end
            ST_RD: begin
              mem_addr <= mem_addr + 1'b1;
              rd_req   <= 1'b1;
            end
            default: ;
          endcase
        end

        if (drop && out_phase) begin
          if (bitcnt == 3'd0) begin
            so     <= out_src[7];
            shout  <= {out_src[6:0], 1'b0};
            out_en <= 1'b1;
          end else begin
            so    <= shout[7];
            shout <= {shout[6:0], 1'b0};
          end
        end
      end
    end
  end

endmodule

// File: rtl/spi_mem_front_chk.sv
module spi_mem_front_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       s_cs,
  input logic       held,
  input logic [2:0] bitcnt,
  input logic       in_dead,
  input logic       in_rd,
  input logic       so_oe,
  input logic       wr_allow,
  input logic       cmd_wren,
  input logic       cmd_wrdi,
  input logic       rd_req,
  input logic       wr_stb,
  input logic       sr_wr_stb
);

  // R11
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_wren, cmd_wrdi, rd_req, wr_stb, sr_wr_stb}));

  // R6
  wr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb || sr_wr_stb) |-> $past(wr_allow));

  // R10
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !s_cs) |=> $stable(bitcnt));

  // R8
  dead_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_dead && !s_cs) |=> (in_dead && !so_oe &&
      !(cmd_wren || cmd_wrdi || rd_req || wr_stb || sr_wr_stb)));

  // R9
  deselect_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_cs |=> (bitcnt == 3'd0 && !held && !so_oe));

  // R4
  rd_req_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> in_rd);

endmodule

bind spi_mem_front spi_mem_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .s_cs(s_cs), .held(held), .bitcnt(bitcnt),
  .in_dead(in_dead), .in_rd(in_rd), .so_oe(so_oe), .wr_allow(wr_allow),
  .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .rd_req(rd_req),
  .wr_stb(wr_stb), .sr_wr_stb(sr_wr_stb)
);

// File: tb/test_spi_mem_front.sv
module test_spi_mem_front;
  localparam int H = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, hold_n = 1'b1, si = 1'b0;
  logic wr_allow = 1'b1;
  logic [7:0] sr_data = 8'hC3;
  logic so, so_oe, cmd_wren, cmd_wrdi, rd_req, wr_stb, sr_wr_stb;
  logic [12:0] mem_addr;
  logic [7:0] wr_data, rd_data;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [23:0] expq[$];

  function automatic logic [7:0] pat(input logic [12:0] a);
    return {3'b0, a[12:8]} ^ a[7:0] ^ 8'h5A;
  endfunction
  assign rd_data = pat(mem_addr);

  always #5 clk = ~clk;

  spi_mem_front i_spi_mem_front (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .hold_n(hold_n), .si(si),
    .so(so), .so_oe(so_oe), .wr_allow(wr_allow), .rd_data(rd_data), .sr_data(sr_data),
    .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .rd_req(rd_req), .wr_stb(wr_stb),
    .sr_wr_stb(sr_wr_stb), .mem_addr(mem_addr), .wr_data(wr_data)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push_ev(input logic [2:0] k, input logic [12:0] a, input logic [7:0] d);
    expq.push_back({k, a, d});
  endtask

  // scoreboard monitor: 1 wren, 2 wrdi, 3 read fetch, 4 write, 5 status write
  always @(negedge clk) begin
    if (rst_n && (cmd_wren || cmd_wrdi || rd_req || wr_stb || sr_wr_stb)) begin
      logic [2:0] k;
      logic [23:0] act, exp;
      k = cmd_wren ? 3'd1 : cmd_wrdi ? 3'd2 : rd_req ? 3'd3 : wr_stb ? 3'd4 : 3'd5;
      act = {k, (k == 3'd3 || k == 3'd4) ? mem_addr : 13'd0,
             (k == 3'd4 || k == 3'd5) ? wr_data : 8'd0};
      n_chk++;
      if (expq.size() == 0) begin
        n_bad++;
        $display("FAIL R2/R11 unexpected strobe actual=%h expected=none", act);
      end else begin
        exp = expq.pop_front();
        if (act !== exp) begin
          n_bad++;
          $display("FAIL R3/R4/R6/R7 strobe actual=%h expected=%h", act, exp);
        end
      end
    end
  end

  task automatic sel();
    cs_n = 1'b0;
    tick(H);
  endtask

  task automatic desel();
    sck = 1'b0;
    tick(H);
    cs_n = 1'b1;
    tick(2 * H);
  endtask

  // hpos: bit index at which a pause is inserted, -1 for none
  task automatic xbyte(input logic [7:0] tx, input int hpos,
                       output logic [7:0] rx, output int oe_hits, output int oe_hold);
    oe_hits = 0;
    oe_hold = 0;
    for (int b = 7; b >= 0; b--) begin
      sck = 1'b0;
      si = tx[b];
      tick(H);
      if (b == hpos) begin
        hold_n = 1'b0;
        tick(H);
        for (int t = 0; t < 3; t++) begin
          si = ~si;
          sck = 1'b1;
          tick(H);
          oe_hold += so_oe;
          sck = 1'b0;
          tick(H);
          oe_hold += so_oe;
        end
        hold_n = 1'b1;
        si = tx[b];
        tick(H);
      end
      rx[b] = so;
      oe_hits += so_oe;
      sck = 1'b1;
      tick(H);
    end
    sck = 1'b0;
  endtask

  task automatic send(input logic [7:0] tx);
    logic [7:0] rx;
    int a, b;
    xbyte(tx, -1, rx, a, b);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    tick(150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] rx;
    int oe, oeh;

    tick(4);
    // R12 reset state
    chk("R12 oe in reset", so_oe, 0);
    chk("R12 strobes in reset", {cmd_wren, cmd_wrdi, rd_req, wr_stb, sr_wr_stb}, 0);
    rst_n = 1'b1;
    tick(4);
    chk("R12 oe after reset", so_oe, 0);

    // R2 R3 write-enable set and clear, trailing byte ignored
    push_ev(3'd1, 0, 0);
    sel(); send(8'h06); send(8'h06); desel();
    push_ev(3'd2, 0, 0);
    sel(); send(8'h04); desel();

    // R6 write with top address bits dropped
    push_ev(3'd4, 13'h0010, 8'hA1);
    push_ev(3'd4, 13'h0011, 8'hB2);
    push_ev(3'd4, 13'h0012, 8'hC3);
    sel(); send(8'h02); send(8'hE0); send(8'h10);
    send(8'hA1); send(8'hB2); send(8'hC3); desel();

    // R10 pause in the middle of a write data byte
    push_ev(3'd4, 13'h0100, 8'h5A);
    push_ev(3'd4, 13'h0101, 8'h3C);
    sel(); send(8'h02); send(8'h01); send(8'h00); send(8'h5A);
    xbyte(8'h3C, 4, rx, oe, oeh);
    desel();
    chk("R10 oe low during write pause", oeh, 0);

    // R1 R4 read with wrap from 0x1FFF to 0x0000
    push_ev(3'd3, 13'h1FFE, 0);
    push_ev(3'd3, 13'h1FFF, 0);
    push_ev(3'd3, 13'h0000, 0);
    push_ev(3'd3, 13'h0001, 0);
    push_ev(3'd3, 13'h0002, 0);
    sel(); send(8'h03); send(8'hFF); send(8'hFE);
    for (int i = 0; i < 4; i++) begin
      logic [12:0] a;
      a = 13'h1FFE + 13'(i);
      xbyte(8'h00, -1, rx, oe, oeh);
      chk("R4 read byte", rx, pat(a));
      chk("R1 oe during read byte", oe, 8);
    end
    desel();

    // R10 pause in the middle of a read byte
    push_ev(3'd3, 13'h0040, 0);
    push_ev(3'd3, 13'h0041, 0);
    push_ev(3'd3, 13'h0042, 0);
    sel(); send(8'h03); send(8'h00); send(8'h40);
    xbyte(8'h00, -1, rx, oe, oeh);
    chk("R4 read byte 0x40", rx, pat(13'h0040));
    xbyte(8'hFF, 5, rx, oe, oeh);
    chk("R10 read byte kept across pause", rx, pat(13'h0041));
    chk("R10 oe low during read pause", oeh, 0);
    desel();

    // R5 status read repeats
    sel(); send(8'h05);
    xbyte(8'h00, -1, rx, oe, oeh);
    chk("R5 status byte 1", rx, 8'hC3);
    sr_data = 8'h81;
    xbyte(8'h00, -1, rx, oe, oeh);
    chk("R5 status byte 2", rx, 8'h81);
    desel();

    // R7 status write, second byte ignored
    push_ev(3'd5, 0, 8'h8C);
    sel(); send(8'h01); send(8'h8C); send(8'h11); desel();

    // R6 R7 writes refused while wr_allow is low
    wr_allow = 1'b0;
    sel(); send(8'h02); send(8'h00); send(8'h07); send(8'h99); desel();
    sel(); send(8'h01); send(8'h44); desel();
    wr_allow = 1'b1;
    tick(H);

    // R8 unknown command silences the block until reselect
    sel(); send(8'hAB);
    xbyte(8'h06, -1, rx, oe, oeh);
    chk("R8 oe after unknown op", oe, 0);
    xbyte(8'h05, -1, rx, oe, oeh);
    chk("R8 oe stays low", oe, 0);
    desel();

    // R9 abort mid-byte, next select starts cleanly
    sel(); send(8'h02); send(8'h00); send(8'h05);
    for (int b = 7; b >= 4; b--) begin
      sck = 1'b0; si = 1'b1; tick(H);
      sck = 1'b1; tick(H);
    end
    desel();
    push_ev(3'd1, 0, 0);
    sel(); send(8'h06); desel();

    // R9 serial activity while deselected has no effect
    oe = 0;
    for (int t = 0; t < 16; t++) begin
      si = t[0];
      sck = ~sck;
      tick(H);
      oe += so_oe;
    end
    sck = 1'b0;
    tick(H);
    chk("R9 oe while deselected", oe, 0);
    sr_data = 8'h6E;
    sel(); send(8'h05);
    xbyte(8'h00, -1, rx, oe, oeh);
    chk("R9 framing after idle clocks", rx, 8'h6E);
    desel();

    tick(50);
    chk("R2 all expected strobes seen", expq.size(), 0);
    done = 1;
    summary();
    $finish;
  end
endmodule